// File: doc/BRIEF.md
# Refresh Row Address Generator

This block produces the address and strobe that an 8-bit processor places on its bus during the refresh slot that follows each opcode fetch. It holds two 8-bit registers: a row register, whose low seven bits advance once per refresh, and a page register. A one-cycle pulse on the fetch-complete input starts a refresh. On the next clock the block pulls its active-low strobe low for one clock. While the strobe is low, the address carries the page register on the upper byte and the row register, as it stood before the step, on the lower byte. The row register then steps.

The top bit of the row register never takes part in counting. It keeps whatever value software last loaded into it, so a consumer can use it as a latched output bit or as a bank selector. Software can load either register through its own load port at any time. A row load wins over a refresh step that falls in the same cycle. Downstream logic uses the strobe and address to refresh dynamic memory rows, or as a free sequential pointer into a frame buffer that advances without stalling the processor.

Top module: `rfsh_addr_unit`

## Requirements
- R1: Synchronous active-high reset clears the row and page registers to zero, drives `rfsh_n_o` high and `rfsh_addr_o` to 0x0000. The first refresh after reset therefore shows address 0x0000.
- R2: A high `fetch_done_i` sampled at a rising edge makes `rfsh_n_o` low for exactly the following clock. When `fetch_done_i` is low at an edge, `rfsh_n_o` is high for the following clock.
- R3: While `rfsh_n_o` is low, `rfsh_addr_o[7:0]` equals the row register as it was at the edge that sampled the fetch pulse, before that refresh's step. `rfsh_addr_o[15:8]` equals the page register at that same edge.
- R4: Each refresh that is not overridden by a row load adds one, modulo 128, to row bits [6:0].
- R5: Row bit 7 never changes through counting. A row value of 0x7F steps to 0x00, and 0xFF steps to 0x80.
- R6: A row load replaces all eight row bits. It takes priority over a refresh step in the same cycle, so the next refresh shows exactly the loaded value.
- R7: A page load replaces the page register and leaves the row register untouched. Refreshes never alter the page register.
- R8: While `rfsh_n_o` is high, `rfsh_addr_o` is 0x0000.
- R9: Fetch pulses on consecutive clocks give consecutive strobe clocks whose row bytes step by one. A row load with no fetch produces no strobe and no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_done_i | input | 1 | One-cycle pulse: an opcode fetch has completed |
| row_ld_i | input | 1 | Load the row register from `row_ld_data_i` |
| row_ld_data_i | input | 8 | Value for a row load, bit 7 included |
| pg_ld_i | input | 1 | Load the page register from `pg_ld_data_i` |
| pg_ld_data_i | input | 8 | Value for a page load |
| rfsh_addr_o | output | 16 | Refresh address: page on the high byte, row on the low byte; zero when idle |
| rfsh_n_o | output | 1 | Active-low refresh strobe, one clock per fetch pulse |

## Verification
The bench walks the row register through 300 steps from zero and through 300 steps from a preset with the top bit set. A design that let the carry reach bit 7, or that wrapped at 256, would show 0x80 after 0x7F or 0x00 after 0xFF. It preloads all 256 row values with a fetch in the same cycle. A design that gave the step priority over the load would show the loaded value plus one on the following refresh. A design that showed the post-step value during the strobe would be off by one on every refresh. The bench also sweeps all 256 page values, sends back-to-back fetch pulses, and applies loads with no fetch. These tests catch a stretched or missing strobe, a page that drifts with refreshes, and an address that leaks out while the strobe is high.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned DEF_ROW_W = 8;
  localparam int unsigned DEF_CNT_W = 7;
  localparam int unsigned DEF_PG_W  = 8;
endpackage

// File: rtl/rfsh_row_reg.sv
module rfsh_row_reg #(
  parameter int unsigned ROW_W = rfsh_pkg::DEF_ROW_W,
  parameter int unsigned CNT_W = rfsh_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [ROW_W-1:0] ld_data_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_next;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = row_q[CNT_W-1:0] + ONE;

  // Only the low CNT_W bits count; any bits above them hold their preset.
  generate
    if (CNT_W < ROW_W) begin : g_held_top
      assign row_next = {row_q[ROW_W-1:CNT_W], cnt_inc};
    end else begin : g_full_count
      assign row_next = cnt_inc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
    end else if (ld_i) begin
      row_q <= ld_data_i;   // load wins over step
    end else if (step_i) begin
      row_q <= row_next;
    end
  end

  assign row_o = row_q;
endmodule

// File: rtl/rfsh_page_reg.sv
module rfsh_page_reg #(
  parameter int unsigned PG_W = rfsh_pkg::DEF_PG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_i,
  input  logic [PG_W-1:0] ld_data_i,
  output logic [PG_W-1:0] pg_o
);
  logic [PG_W-1:0] pg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q <= '0;
    end else if (ld_i) begin
      pg_q <= ld_data_i;
    end
  end

  assign pg_o = pg_q;
endmodule

// File: rtl/rfsh_strobe_gen.sv
module rfsh_strobe_gen #(
  parameter int unsigned ROW_W = rfsh_pkg::DEF_ROW_W,
  parameter int unsigned PG_W  = rfsh_pkg::DEF_PG_W,
  localparam int unsigned ADDR_W = ROW_W + PG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [PG_W-1:0]   pg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              strobe_n_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              strobe_n_q;

  // Captures the pre-step row at the same edge where the row register steps.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      strobe_n_q <= 1'b1;
    end else begin
      strobe_n_q <= ~fetch_i;
      addr_q     <= fetch_i ? {pg_i, row_i} : '0;
    end
  end

  assign addr_o     = addr_q;
  assign strobe_n_o = strobe_n_q;
endmodule

// File: rtl/rfsh_addr_unit.sv
module rfsh_addr_unit #(
  parameter int unsigned ROW_W = rfsh_pkg::DEF_ROW_W,
  parameter int unsigned CNT_W = rfsh_pkg::DEF_CNT_W,
  parameter int unsigned PG_W  = rfsh_pkg::DEF_PG_W,
  localparam int unsigned ADDR_W = ROW_W + PG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_done_i,
  input  logic              row_ld_i,
  input  logic [ROW_W-1:0]  row_ld_data_i,
  input  logic              pg_ld_i,
  input  logic [PG_W-1:0]   pg_ld_data_i,
  output logic [ADDR_W-1:0] rfsh_addr_o,
  output logic              rfsh_n_o
);
  logic [ROW_W-1:0] row_cur;
  logic [PG_W-1:0]  pg_cur;

  rfsh_row_reg #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_row (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (row_ld_i),
    .ld_data_i (row_ld_data_i),
    .step_i    (fetch_done_i),
    .row_o     (row_cur)
  );

  rfsh_page_reg #(.PG_W(PG_W)) u_pg (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (pg_ld_i),
    .ld_data_i (pg_ld_data_i),
    .pg_o      (pg_cur)
  );

  rfsh_strobe_gen #(.ROW_W(ROW_W), .PG_W(PG_W)) u_stb (
    .clk        (clk),
    .rst        (rst),
    .fetch_i    (fetch_done_i),
    .row_i      (row_cur),
    .pg_i       (pg_cur),
    .addr_o     (rfsh_addr_o),
    .strobe_n_o (rfsh_n_o)
  );
endmodule

// File: rtl/rfsh_addr_unit_chk.sv
module rfsh_addr_unit_chk #(
  parameter int unsigned ROW_W = rfsh_pkg::DEF_ROW_W,
  parameter int unsigned CNT_W = rfsh_pkg::DEF_CNT_W,
  parameter int unsigned PG_W  = rfsh_pkg::DEF_PG_W,
  localparam int unsigned ADDR_W = ROW_W + PG_W
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_done_i,
  input logic              row_ld_i,
  input logic [ROW_W-1:0]  row_ld_data_i,
  input logic              pg_ld_i,
  input logic [PG_W-1:0]   pg_ld_data_i,
  input logic [ADDR_W-1:0] rfsh_addr_o,
  input logic              rfsh_n_o
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rfsh_n_o && rfsh_addr_o == '0));

  p_strobe_on_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_done_i |=> !rfsh_n_o);

  p_strobe_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !fetch_done_i |=> rfsh_n_o);

  p_idle_addr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rfsh_n_o |-> rfsh_addr_o == '0);

  // R4 / R5 / R9: back-to-back refreshes with no row load in between
  p_row_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_n_o && !$past(rfsh_n_o) && !$past(row_ld_i, 2)) |->
      (rfsh_addr_o[CNT_W-1:0] == CNT_W'($past(rfsh_addr_o[CNT_W-1:0]) + 1'b1)));

  p_top_bit_held_r5: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_n_o && !$past(rfsh_n_o) && !$past(row_ld_i, 2)) |->
      (rfsh_addr_o[ROW_W-1:CNT_W] == $past(rfsh_addr_o[ROW_W-1:CNT_W])));

  p_load_shown_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(row_ld_i, 2) && $past(fetch_done_i)) |->
      (rfsh_addr_o[ROW_W-1:0] == $past(row_ld_data_i, 2)));

  p_page_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_n_o && !$past(rfsh_n_o) && !$past(pg_ld_i, 2)) |->
      (rfsh_addr_o[ADDR_W-1:ROW_W] == $past(rfsh_addr_o[ADDR_W-1:ROW_W])));

  p_page_shown_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(pg_ld_i, 2) && $past(fetch_done_i)) |->
      (rfsh_addr_o[ADDR_W-1:ROW_W] == $past(pg_ld_data_i, 2)));
endmodule

bind rfsh_addr_unit rfsh_addr_unit_chk #(
  .ROW_W(ROW_W), .CNT_W(CNT_W), .PG_W(PG_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_done_i  (fetch_done_i),
  .row_ld_i      (row_ld_i),
  .row_ld_data_i (row_ld_data_i),
  .pg_ld_i       (pg_ld_i),
  .pg_ld_data_i  (pg_ld_data_i),
  .rfsh_addr_o   (rfsh_addr_o),
  .rfsh_n_o      (rfsh_n_o)
);

// File: tb/tb_rfsh_addr_unit.sv
module tb_rfsh_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_done_i = 1'b0;
  logic        row_ld_i = 1'b0;
  logic [7:0]  row_ld_data_i = '0;
  logic        pg_ld_i = 1'b0;
  logic [7:0]  pg_ld_data_i = '0;
  logic [15:0] rfsh_addr_o;
  logic        rfsh_n_o;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  int unsigned cyc = 0;
  logic [7:0]  m_row = '0;
  logic [7:0]  m_pg = '0;

  rfsh_addr_unit dut (
    .clk           (clk),
    .rst           (rst),
    .fetch_done_i  (fetch_done_i),
    .row_ld_i      (row_ld_i),
    .row_ld_data_i (row_ld_data_i),
    .pg_ld_i       (pg_ld_i),
    .pg_ld_data_i  (pg_ld_data_i),
    .rfsh_addr_o   (rfsh_addr_o),
    .rfsh_n_o      (rfsh_n_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input logic exp_n, input logic [15:0] exp_a);
    vectors = vectors + 1;
    if (rfsh_n_o !== exp_n || rfsh_addr_o !== exp_a) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual strobe_n=%b addr=%h expected strobe_n=%b addr=%h",
               req, rfsh_n_o, rfsh_addr_o, exp_n, exp_a);
    end
  endtask

  // Drive one cycle, sample 2 ns after the edge, then advance the model.
  task automatic step(input logic f, input logic rl, input logic [7:0] rd,
                      input logic pl, input logic [7:0] pd, input string req);
    logic [15:0] exp_a;
    fetch_done_i  = f;
    row_ld_i      = rl;
    row_ld_data_i = rd;
    pg_ld_i       = pl;
    pg_ld_data_i  = pd;
    exp_a = f ? {m_pg, m_row} : 16'h0000;
    @(posedge clk);
    #2;
    check(req, ~f, exp_a);
    if (rl)     m_row = rd;
    else if (f) m_row = {m_row[7], m_row[6:0] + 7'd1};
    if (pl)     m_pg = pd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", 1'b1, 16'h0000);
    rst = 1'b0;
    // R1: first refresh after reset shows zero
    step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R1");
    // R4 R5 R9: long back-to-back walk from zero, crossing 0x7F -> 0x00
    for (int k = 0; k < 300; k++) step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R4");
    // R8: idle cycles show zero address
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R8");
    // R5: preset bit 7, walk across 0xFF -> 0x80
    step(1'b0, 1'b1, 8'hF0, 1'b0, 8'h00, "R9");
    for (int k = 0; k < 300; k++) step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R5");
    // R6: every row preset loaded in the same cycle as a fetch, then shown
    for (int v = 0; v < 256; v++) begin
      step(1'b1, 1'b1, 8'(v), 1'b0, 8'h00, "R6");
      step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R6");
      step(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
    end
    // R3 R7: every page value, refresh shows it on the high byte
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 1'b0, 8'h00, 1'b1, 8'(v), "R7");
      step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
      step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R7");
    end
    // R9: load without fetch gives no strobe and no step
    step(1'b0, 1'b1, 8'h7E, 1'b1, 8'hA5, "R9");
    step(1'b0, 1'b1, 8'h7F, 1'b0, 8'h00, "R9");
    step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R5");
    step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R5");
    // R2: sparse fetches with gaps of varying length
    for (int k = 0; k < 64; k++) step(((k % 3) == 0) || ((k % 7) == 1), 1'b0, 8'h00,
                                       ((k % 11) == 5), 8'(k * 13), "R2");
    // R1: reset mid-run clears both registers
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1", 1'b1, 16'h0000);
    rst = 1'b0;
    m_row = '0;
    m_pg  = '0;
    step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R1");
    step(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule